// File: doc/BRIEF.md
# Two-Wire Potentiometer Slave Front End

This block is the bus-facing half of a dual digitally controlled potentiometer. It watches the serial clock and data lines of a two-wire bus with its own system clock, finds start and stop conditions, assembles bytes most significant bit first and answers each accepted byte with an acknowledge. The data line is driven only through a pull-low enable, so the pin stays open-drain.

The first byte of a transaction is the device address: a fixed type nibble followed by four bits that must match the strap pins. If it matches and no internal store is running, the block acknowledges and passes that byte and every later one, tagged with its position in the transaction, to a command decoder. While a store is running a matching address gets no acknowledge, so the master can poll until the part answers again. When the decoder asks for a read, the next byte is shifted out from a supplied value.

Storage and the meaning of instructions live in the decoder; this block only frames bytes and runs the handshake.

Top module: `twowire_pot_slave`

## Requirements
- R1: After reset `sda_drive_low`, `rx_valid` and `wp_held` are 0.
- R2: No bit is taken and no acknowledge is given before a start condition (SDA falling while SCL high); after a stop condition (SDA rising while SCL high) further clocks are ignored until the next start.
- R3: The first byte after a start is accepted only when its bits 7:4 equal 0101 and bits 3:0 equal `strap_addr` latched at the start; otherwise it gets no acknowledge and the rest of the transaction is ignored.
- R4: `sda_drive_low` is asserted only in an acknowledge slot given by the block or for a 0 bit of a read byte, and it changes only while SCL is low.
- R5: Every accepted byte is acknowledged (SDA held low through the ninth SCL pulse) and reported by a one-cycle `rx_valid` pulse after the eighth SCL falling edge, with `rx_byte` and `rx_index` (0 for the address, then 1, 2, ..., saturating at 2^IDX_W-1).
- R6: While `store_busy` is high, a matching address gets no acknowledge and no report; once it is low, a matching address is acknowledged again.
- R7: A start condition in the middle of a byte discards the partial byte and restarts address reception.
- R8: If `rd_req` is high at the SCL falling edge that ends the acknowledge of a byte with index 1 or more, the next byte is `tx_byte` sent MSB first, each bit placed after SCL falls; SDA is released after the eighth bit and the master's acknowledge slot is not driven.
- R9: `wp_held` takes the value of `wp_in` at each start condition and holds it until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low reset |
| scl_in | input | 1 | Bus serial clock |
| sda_in | input | 1 | Bus serial data as seen on the wire |
| strap_addr | input | 4 | Pin-strapped low address nibble |
| wp_in | input | 1 | Write-protect pin |
| store_busy | input | 1 | High while an internal nonvolatile store runs |
| rd_req | input | 1 | Decoder request to send the next byte |
| tx_byte | input | 8 | Byte to send on a read |
| sda_drive_low | output | 1 | Pull SDA low when 1, release when 0 |
| rx_valid | output | 1 | One-cycle pulse: a byte was accepted |
| rx_byte | output | 8 | Accepted byte |
| rx_index | output | IDX_W | Position of the byte in the transaction |
| wp_held | output | 1 | Write-protect value captured at start |

## Verification
Each bus edge passes two synchronizer flops and one compare register, so `rx_valid` and a change of `sda_drive_low` are due three system clocks after the SCL falling edge that causes them. The bench holds every SCL level for ten or more system clocks and samples the acknowledge and read bits in the middle of the SCL high phase, well after the drive has settled. A behavioural model in the bench marks, on every clock, the windows where the slave may pull SDA low and collects the expected byte reports in a queue that is compared with the reports seen after each transaction.

// File: rtl/twowire_pot_slave.sv
module twowire_pot_slave #(
  parameter logic [3:0] TYPE_CODE = 4'b0101,
  parameter int         IDX_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic [3:0]       strap_addr,
  input  logic             wp_in,
  input  logic             store_busy,
  input  logic             rd_req,
  input  logic [7:0]       tx_byte,
  output logic             sda_drive_low,
  output logic             rx_valid,
  output logic [7:0]       rx_byte,
  output logic [IDX_W-1:0] rx_index,
  output logic             wp_held
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic [2:0] scl_p, sda_p;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_in};
      sda_p <= {sda_p[1:0], sda_in};
    end

  wire scl_s = scl_p[1], scl_d = scl_p[2];
  wire sda_s = sda_p[1], sda_d = sda_p[2];
  wire scl_rise  = scl_s & ~scl_d;
  wire scl_fall  = ~scl_s & scl_d;
  wire bus_start = scl_s & scl_d & sda_d & ~sda_s;
  wire bus_stop  = scl_s & scl_d & ~sda_d & sda_s;

  logic             active, addressed, in_ack, tx_mode;
  logic [3:0]       bitcnt;
  logic [7:0]       sh;
  logic [IDX_W-1:0] idx;
  logic [3:0]       strap_q;

  wire addr_ok = (sh == {TYPE_CODE, strap_q});

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active <= 1'b0; addressed <= 1'b0; in_ack <= 1'b0; tx_mode <= 1'b0;
      bitcnt <= '0; sh <= '0; idx <= '0; strap_q <= '0;
      sda_drive_low <= 1'b0; rx_valid <= 1'b0; rx_byte <= '0; rx_index <= '0;
      wp_held <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (bus_start) begin
        active <= 1'b1; addressed <= 1'b0; in_ack <= 1'b0; tx_mode <= 1'b0;
        bitcnt <= '0; idx <= '0; sda_drive_low <= 1'b0;
        strap_q <= strap_addr; wp_held <= wp_in;
      end else if (bus_stop) begin
        active <= 1'b0; addressed <= 1'b0; in_ack <= 1'b0; tx_mode <= 1'b0;
        sda_drive_low <= 1'b0;
      end else if (active) begin
        if (scl_rise && !in_ack && bitcnt != 4'd8) begin
          bitcnt <= bitcnt + 4'd1;
          if (!tx_mode) sh <= {sh[6:0], sda_s};
        end
        if (scl_fall) begin
          if (in_ack) begin
            in_ack <= 1'b0;
            bitcnt <= '0;
            if (idx != IDX_MAX) idx <= idx + 1'b1;
            if (!tx_mode && idx != '0 && rd_req) begin
              tx_mode <= 1'b1;
              sh <= tx_byte;
              sda_drive_low <= ~tx_byte[7];
            end else begin
              tx_mode <= 1'b0;
              sda_drive_low <= 1'b0;
            end
          end else if (bitcnt == 4'd8) begin
            in_ack <= 1'b1;
            if (tx_mode) begin
              sda_drive_low <= 1'b0;
            end else if (!addressed && !(addr_ok && !store_busy)) begin
              active <= 1'b0;
            end else begin
              addressed <= 1'b1;
              sda_drive_low <= 1'b1;
              rx_valid <= 1'b1;
              rx_byte <= sh;
              rx_index <= idx;
            end
          end else if (tx_mode && bitcnt != 4'd0) begin
            sh <= {sh[6:0], 1'b0};
            sda_drive_low <= ~sh[6];
          end
        end
      end
    end

  a_r5_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  a_r3_addr_match: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_index == '0) |-> rx_byte == {TYPE_CODE, strap_addr});
  a_r6_busy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_index == '0) |-> !$past(store_busy));
  a_r4_drive_on_low_scl: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_drive_low) |-> !$past(scl_s));
  a_r2_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> (!sda_drive_low && !rx_valid));
endmodule

// File: tb/twowire_pot_slave_tb.sv
module twowire_pot_slave_tb;
  localparam int IDX_W = 2;
  localparam int Q = 10;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [3:0] strap = 4'hA;
  logic wp = 1'b0, busy = 1'b0, rd_req = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic drv, rx_valid, wp_held;
  logic [7:0] rx_byte;
  logic [IDX_W-1:0] rx_index;
  wire sda_bus = m_sda & ~drv;

  twowire_pot_slave #(.TYPE_CODE(4'b0101), .IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus),
    .strap_addr(strap), .wp_in(wp), .store_busy(busy), .rd_req(rd_req),
    .tx_byte(tx_byte), .sda_drive_low(drv), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rx_index(rx_index), .wp_held(wp_held));

  int total = 0, bad = 0, drv_viol = 0;
  bit may_drive = 1'b0;
  int exp_q[$], got_q[$];

  always @(posedge clk) if (rst_n && rx_valid) got_q.push_back(int'(rx_index) * 256 + int'(rx_byte));
  always @(negedge clk) if (rst_n && drv && !may_drive) drv_viol++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; hold(); m_scl = 1'b1; hold(); m_sda = 1'b0; hold(); m_scl = 1'b0; hold();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; hold(); m_scl = 1'b1; hold(); m_sda = 1'b1; hold();
  endtask

  task automatic send_bit(input bit b);
    m_sda = b; hold(); m_scl = 1'b1; hold(); hold(); m_scl = 1'b0; hold();
  endtask

  task automatic wr_byte(input logic [7:0] b, input bit exp_ack, input bit then_read,
                         input string req);
    bit acked;
    for (int i = 7; i > 0; i--) send_bit(b[i]);
    m_sda = b[0]; hold(); m_scl = 1'b1; hold(); hold(); m_scl = 1'b0;
    may_drive = exp_ack; hold();
    m_sda = 1'b1; hold(); m_scl = 1'b1; hold();
    acked = (sda_bus == 1'b0);
    hold(); m_scl = 1'b0; hold();
    may_drive = then_read;
    chk(acked == exp_ack, req, int'(acked), int'(exp_ack));
  endtask

  task automatic rd_byte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; hold(); m_scl = 1'b1; hold();
      v[i] = sda_bus;
      hold(); m_scl = 1'b0; hold();
    end
    may_drive = 1'b0;
    send_bit(1'b1);
  endtask

  task automatic check_events(input string req);
    chk(got_q.size() == exp_q.size(), req, got_q.size(), exp_q.size());
    if (got_q.size() == exp_q.size())
      foreach (exp_q[i]) chk(got_q[i] == exp_q[i], req, got_q[i], exp_q[i]);
    got_q.delete();
    exp_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (5) @(negedge clk);
    chk(drv == 1'b0 && rx_valid == 1'b0 && wp_held == 1'b0, "R1 reset outputs",
        {drv, rx_valid, wp_held}, 0);
    rst_n = 1'b1;
    hold();

    // R2: bits before any start are ignored
    m_scl = 1'b0; hold();
    wr_byte(8'h5A, 1'b0, 1'b0, "R2 no ack before start");
    m_scl = 1'b1; hold();
    check_events("R2 no report before start");

    // R3/R5/R9: plain write, three bytes
    wp = 1'b1;
    bus_start();
    wp = 1'b0;
    wr_byte(8'h5A, 1'b1, 1'b0, "R3 matching address acked");
    wr_byte(8'hA9, 1'b1, 1'b0, "R5 instruction byte acked");
    wr_byte(8'h3C, 1'b1, 1'b0, "R5 data byte acked");
    bus_stop();
    exp_q.push_back(16'h005A); exp_q.push_back(16'h01A9); exp_q.push_back(16'h023C);
    check_events("R5 byte reports");
    chk(wp_held == 1'b1, "R9 write protect latched at start", wp_held, 1);

    // R2: clocks after stop are ignored
    m_scl = 1'b0; hold();
    wr_byte(8'h5A, 1'b0, 1'b0, "R2 no ack after stop");
    m_scl = 1'b1; hold();
    check_events("R2 no report after stop");

    // R3: wrong type nibble, then wrong strap nibble
    bus_start();
    wr_byte(8'h7A, 1'b0, 1'b0, "R3 wrong type no ack");
    wr_byte(8'h11, 1'b0, 1'b0, "R3 rest ignored");
    bus_stop();
    bus_start();
    wr_byte(8'h5B, 1'b0, 1'b0, "R3 wrong strap no ack");
    bus_stop();
    check_events("R3 no report on mismatch");

    // R6: busy suppresses the address acknowledge
    busy = 1'b1;
    bus_start();
    wr_byte(8'h5A, 1'b0, 1'b0, "R6 busy no ack");
    bus_stop();
    check_events("R6 no report while busy");
    busy = 1'b0;
    bus_start();
    wp = 1'b1;
    wr_byte(8'h5A, 1'b1, 1'b0, "R6 ack after store ends");
    wr_byte(8'h80, 1'b1, 1'b0, "R6 instruction after poll");
    bus_stop();
    exp_q.push_back(16'h005A); exp_q.push_back(16'h0180);
    check_events("R6 reports after store ends");
    chk(wp_held == 1'b0, "R9 later pin change ignored", wp_held, 0);
    wp = 1'b0;

    // R8: read of one byte
    tx_byte = 8'hB6;
    rd_req = 1'b1;
    bus_start();
    wr_byte(8'h5A, 1'b1, 1'b0, "R8 address for read");
    wr_byte(8'h9F, 1'b1, 1'b1, "R8 instruction for read");
    rd_byte(v);
    rd_req = 1'b0;
    bus_stop();
    chk(v == 8'hB6, "R8 read data", v, 8'hB6);
    exp_q.push_back(16'h005A); exp_q.push_back(16'h019F);
    check_events("R8 reports around read");

    // R7: start in the middle of a byte
    bus_start();
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_start();
    wr_byte(8'h5A, 1'b1, 1'b0, "R7 address after restart");
    wr_byte(8'h42, 1'b1, 1'b0, "R7 byte after restart");
    bus_stop();
    exp_q.push_back(16'h005A); exp_q.push_back(16'h0142);
    check_events("R7 reports after restart");

    // R5: index saturates at 3
    bus_start();
    wr_byte(8'h5A, 1'b1, 1'b0, "R5 address");
    wr_byte(8'h01, 1'b1, 1'b0, "R5 byte 1");
    wr_byte(8'h02, 1'b1, 1'b0, "R5 byte 2");
    wr_byte(8'h03, 1'b1, 1'b0, "R5 byte 3");
    wr_byte(8'h04, 1'b1, 1'b0, "R5 byte 4");
    bus_stop();
    exp_q.push_back(16'h005A); exp_q.push_back(16'h0101); exp_q.push_back(16'h0202);
    exp_q.push_back(16'h0303); exp_q.push_back(16'h0304);
    check_events("R5 index saturation");

    hold();
    chk(drv_viol == 0, "R4 drive only in slave slots", drv_viol, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule